// File: doc/BRIEF.md
# Two-Channel Down-Counting Interval Timer

This peripheral holds two independent 24-bit down-counters behind a small synchronous 32-bit register bus. Each channel has a control word, a reload value and an interrupt line. The control word sets four things: whether the channel runs, whether its interrupt line is enabled, whether it repeats or fires once, and a clock divider. The counter steps down once every `prescale + 1` clock cycles. When a step would take it from 1 to 0, the channel expires. It then either reloads and keeps going, or stops.

Both channels report expiry into one shared flag register. Software clears a flag by writing a 1 to its bit. The second channel also makes its running count readable, so it can serve as a free-running time base. A typical setup runs channel 1 periodically from the maximum reload value as a time base, and uses channel 0 for one-shot or periodic events.

Bus reads are combinational on `bus_addr`. Writes take effect on the clock edge where `bus_we` is high.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every mapped register reads zero, both channels are stopped and both interrupt lines are low.
- R2: Control word layout (offset 0x0 for channel 0, 0x4 for channel 1). Bit 30 is run, bit 29 is interrupt enable, bit 27 is repeat (1 = periodic, 0 = one-shot) and bits [7:0] are the prescale value. All other bits read zero. The reload value (0x8 for channel 0, 0xC for channel 1) reads back its low 24 bits only.
- R3: A running counter decrements exactly once every `prescale + 1` clock cycles.
- R4: Setting run while the count is zero loads the reload value. With prescale P and reload L, the flag appears L·(P+1) cycles after the write edge and not earlier.
- R5: In one-shot mode, expiry sets the channel flag, leaves the count at zero and clears the run bit.
- R6: In periodic mode, expiry sets the flag, reloads the counter and keeps the run bit set, so the flag recurs every L·(P+1) cycles.
- R7: Clearing run freezes the count. Setting run again while the count is nonzero resumes from the frozen value without reloading.
- R8: Flag register at offset 0x18. Bit 0 is channel 0 and bit 1 is channel 1. Writing 1 to a bit clears it; writing 0 leaves it unchanged.
- R9: If an expiry and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: A channel's interrupt line is high exactly when its flag is set and its interrupt enable bit is 1. The flag still sets when the enable is 0.
- R11: Offset 0x14 returns channel 1's running count, which decreases over time.
- R12: Unmapped offsets read zero, and writes to them change no register.
- R13: The two channels are independent: activity on one never changes the count, flag or interrupt line of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq0 | output | 1 | Channel 0 interrupt |
| irq1 | output | 1 | Channel 1 interrupt |

## Verification
The bench builds the block with its default parameters: 24-bit counters, an 8-bit prescale field and an 8-bit address. Small reload and prescale values therefore make expiry arrive within a few cycles. This puts exact-edge timing within reach for one-shot, periodic, halt-and-resume and the collision between set and clear. Keeping the full 24-bit width means the reload truncation and the running-count readback are checked at their real field widths.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W  = 32;
    localparam int N_CH    = 2;

    localparam int RUN_BIT = 30;
    localparam int IEN_BIT = 29;
    localparam int REP_BIT = 27;

    localparam logic [7:0] OFF_CTRL0 = 8'h00;
    localparam logic [7:0] OFF_CTRL1 = 8'h04;
    localparam logic [7:0] OFF_LOAD0 = 8'h08;
    localparam logic [7:0] OFF_LOAD1 = 8'h0C;
    localparam logic [7:0] OFF_LIVE1 = 8'h14;
    localparam logic [7:0] OFF_FLAGS = 8'h18;

    localparam int PSC_W = 8;

    typedef struct packed {
        logic             run;
        logic             irq_en;
        logic             repeat_mode;
        logic [PSC_W-1:0] pscale;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LOAD,
        SEL_LIVE,
        SEL_FLAGS
    } sel_e;

    typedef struct packed {
        sel_e sel;
        logic ch;
    } dec_t;

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run         = w[RUN_BIT];
        c.irq_en      = w[IEN_BIT];
        c.repeat_mode = w[REP_BIT];
        c.pscale      = w[PSC_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[RUN_BIT]     = c.run;
        w[IEN_BIT]     = c.irq_en;
        w[REP_BIT]     = c.repeat_mode;
        w[PSC_W-1:0]   = c.pscale;
        return w;
    endfunction

    function automatic dec_t decode_off(input logic [7:0] off);
        dec_t d;
        d.sel = SEL_NONE;
        d.ch  = 1'b0;
        case (off)
            OFF_CTRL0: begin d.sel = SEL_CTRL;  d.ch = 1'b0; end
            OFF_CTRL1: begin d.sel = SEL_CTRL;  d.ch = 1'b1; end
            OFF_LOAD0: begin d.sel = SEL_LOAD;  d.ch = 1'b0; end
            OFF_LOAD1: begin d.sel = SEL_LOAD;  d.ch = 1'b1; end
            OFF_LIVE1: begin d.sel = SEL_LIVE;  d.ch = 1'b1; end
            OFF_FLAGS: begin d.sel = SEL_FLAGS; d.ch = 1'b0; end
            default:   begin d.sel = SEL_NONE;  d.ch = 1'b0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] pscale,
    output logic            tick
);
    logic [PS_W-1:0] div_q;

    assign tick = run && (div_q >= pscale);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              load_we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  load_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              tick_o,
    output logic              expire_o
);
    ctrl_t new_ctrl;
    logic  start;
    logic  last_step;

    assign new_ctrl  = word_to_ctrl(wdata);
    assign start     = ctrl_we && new_ctrl.run && !ctrl_q.run && (cnt_q == '0);
    assign last_step = (cnt_q <= CNT_W'(1));
    assign expire_o  = tick_o && last_step;

    tmr_prescaler #(
        .PS_W (PSC_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (start),
        .pscale  (ctrl_q.pscale),
        .tick    (tick_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= new_ctrl;
            end
            if (expire_o && !ctrl_q.repeat_mode) begin
                ctrl_q.run <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
        end else if (load_we) begin
            load_q <= wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load_q;
        end else if (tick_o) begin
            if (last_step) begin
                cnt_q <= ctrl_q.repeat_mode ? load_q : '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] set_evt,
    output logic [N-1:0] flags_q
);
    logic [N-1:0] keep;

    assign keep = clr_we ? ~clr_mask : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & keep) | set_evt;
        end
    end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq0,
    output logic              irq1
);
    localparam int FLAG_PAD = DATA_W - N_CH;
    localparam int CNT_PAD  = DATA_W - CNT_W;

    dec_t                        dec;
    logic                        addr_hit;
    logic [N_CH-1:0]             ctrl_wr;
    logic [N_CH-1:0]             load_wr;
    logic                        flags_wr;
    ctrl_t                       ctrl_v [N_CH];
    logic [N_CH-1:0][CNT_W-1:0]  load_v;
    logic [N_CH-1:0][CNT_W-1:0]  cnt_v;
    logic [N_CH-1:0]             tick_v;
    logic [N_CH-1:0]             expire_v;
    logic [N_CH-1:0]             run_v;
    logic [N_CH-1:0]             rep_v;
    logic [N_CH-1:0]             ien_v;
    logic [N_CH-1:0]             flags_v;

    assign addr_hit = (bus_addr >> 8) == '0;
    assign dec      = addr_hit ? decode_off(bus_addr[7:0]) : '{sel: SEL_NONE, ch: 1'b0};
    assign flags_wr = bus_we && (dec.sel == SEL_FLAGS);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign ctrl_wr[g] = bus_we && (dec.sel == SEL_CTRL) && (dec.ch == 1'(g));
        assign load_wr[g] = bus_we && (dec.sel == SEL_LOAD) && (dec.ch == 1'(g));

        tmr_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk      (clk),
            .rst      (rst),
            .ctrl_we  (ctrl_wr[g]),
            .load_we  (load_wr[g]),
            .wdata    (bus_wdata),
            .ctrl_q   (ctrl_v[g]),
            .load_q   (load_v[g]),
            .cnt_q    (cnt_v[g]),
            .tick_o   (tick_v[g]),
            .expire_o (expire_v[g])
        );

        assign run_v[g] = ctrl_v[g].run;
        assign rep_v[g] = ctrl_v[g].repeat_mode;
        assign ien_v[g] = ctrl_v[g].irq_en;
    end

    tmr_flags #(
        .N (N_CH)
    ) u_flags (
        .clk      (clk),
        .rst      (rst),
        .clr_we   (flags_wr),
        .clr_mask (bus_wdata[N_CH-1:0]),
        .set_evt  (expire_v),
        .flags_q  (flags_v)
    );

    assign irq0 = flags_v[0] && ien_v[0];
    assign irq1 = flags_v[1] && ien_v[1];

    always_comb begin
        bus_rdata = '0;
        case (dec.sel)
            SEL_CTRL:  bus_rdata = ctrl_to_word(ctrl_v[dec.ch]);
            SEL_LOAD:  bus_rdata = {{CNT_PAD{1'b0}}, load_v[dec.ch]};
            SEL_LIVE:  bus_rdata = {{CNT_PAD{1'b0}}, cnt_v[1]};
            SEL_FLAGS: bus_rdata = {{FLAG_PAD{1'b0}}, flags_v};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_down_timer_chk.sv
module dual_down_timer_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_we,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [31:0]                bus_rdata,
    input logic [N_CH-1:0]            flags_v,
    input logic [N_CH-1:0]            tick_v,
    input logic [N_CH-1:0]            expire_v,
    input logic [N_CH-1:0]            run_v,
    input logic [N_CH-1:0]            rep_v,
    input logic [N_CH-1:0]            ctrl_wr,
    input logic [N_CH-1:0][CNT_W-1:0] cnt_v
);
    logic clr0;
    assign clr0 = bus_we && (bus_addr == ADDR_W'(OFF_FLAGS)) && bus_wdata[0];

    AST_RESET_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> bus_rdata == 32'd0); // R1

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (run_v[1] && tick_v[1] && cnt_v[1] > CNT_W'(1)) |=> cnt_v[1] == $past(cnt_v[1]) - 1'b1); // R3

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run_v[1] && !ctrl_wr[1]) |=> $stable(cnt_v[1])); // R7

    AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (rst)
        (expire_v[0] && !rep_v[0]) |=> !run_v[0]); // R5

    AST_PERIODIC_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
        (expire_v[0] && rep_v[0] && !ctrl_wr[0]) |=> run_v[0]); // R6

    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (rst)
        (clr0 && !expire_v[0]) |=> !flags_v[0]); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        expire_v[0] |=> flags_v[0]); // R9

    AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_v[1]) |-> $past(expire_v[1])); // R13
endmodule

bind dual_down_timer dual_down_timer_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flags_v   (flags_v),
    .tick_v    (tick_v),
    .expire_v  (expire_v),
    .run_v     (run_v),
    .rep_v     (rep_v),
    .ctrl_wr   (ctrl_wr),
    .cnt_v     (cnt_v)
);

// File: tb/dual_down_timer_bench.sv
`timescale 1ns/1ps
module dual_down_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq0;
    logic        irq1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_down_timer u_dual_down_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq0      (irq0),
        .irq1      (irq1)
    );

    typedef struct packed {
        logic [7:0]  ch;
        logic [7:0]  ps;
        logic [23:0] load;
        logic [23:0] cyc;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'd0, 8'd0, 24'd1, 24'd1},
        '{8'd0, 8'd1, 24'd3, 24'd6},
        '{8'd1, 8'd2, 24'd4, 24'd12},
        '{8'd1, 8'd0, 24'd5, 24'd5},
        '{8'd0, 8'd3, 24'd2, 24'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_and_check();
        logic [31:0] v;
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        foreach (VEC[i]) begin end
        rd(8'h00, v); check("R1 ctrl0", v, 0);
        rd(8'h04, v); check("R1 ctrl1", v, 0);
        rd(8'h08, v); check("R1 load0", v, 0);
        rd(8'h0C, v); check("R1 load1", v, 0);
        rd(8'h14, v); check("R1 live1", v, 0);
        rd(8'h18, v); check("R1 flags", v, 0);
        check("R1 irq0", {31'd0, irq0}, 0);
        check("R1 irq1", {31'd0, irq1}, 0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        @(negedge clk);
        reset_and_check();

        // R4 R5: one-shot expiry timing from the vector table
        for (int i = 0; i < 5; i++) begin
            logic [7:0]  ca;
            logic [7:0]  la;
            int          c;
            c  = int'(VEC[i].ch);
            ca = 8'(4 * c);
            la = 8'(8'h08 + 4 * c);
            wr(8'h18, 32'h3);
            wr(la, {8'h0, VEC[i].load});
            wr(ca, 32'h6000_0000 | {24'h0, VEC[i].ps});
            wait_cyc(int'(VEC[i].cyc) - 1);
            rd(8'h18, v);
            check("R4 flag not early", v[c], 0);
            wait_cyc(1);
            rd(8'h18, v);
            check("R4 flag at L*(P+1)", v[c], 1);
            check("R10 irq with enable", {31'd0, (c == 0) ? irq0 : irq1}, 1);
            rd(ca, v);
            check("R5 run cleared", v, 32'h2000_0000 | {24'h0, VEC[i].ps});
            if (c == 1) begin
                rd(8'h14, v);
                check("R5 count at zero", v, 0);
            end
        end
        wr(8'h18, 32'h3);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);

        // R2: field layout and truncation
        wr(8'h00, 32'h2F00_F0A5);
        rd(8'h00, v); check("R2 ctrl fields", v, 32'h2800_00A5);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'hAB12_3456);
        rd(8'h08, v); check("R2 load 24 bits", v, 32'h0012_3456);

        // R6 R9: periodic channel 0, load 3, prescale 0
        wr(8'h08, 32'd3);
        wr(8'h00, 32'h6800_0000);
        wait_cyc(2);
        rd(8'h18, v); check("R6 no flag before 3", v, 0);
        wait_cyc(1);
        rd(8'h18, v); check("R6 first expiry", v, 1);
        check("R10 irq0 high", {31'd0, irq0}, 1);
        wr(8'h18, 32'h1);
        rd(8'h18, v); check("R8 cleared by one", v, 0);
        check("R10 irq0 low after clear", {31'd0, irq0}, 0);
        wait_cyc(2);
        rd(8'h18, v); check("R6 second expiry", v, 1);
        rd(8'h00, v); check("R6 run kept", v, 32'h6800_0000);
        wait_cyc(2);
        wr(8'h18, 32'h1);
        rd(8'h18, v); check("R9 set beats clear", v, 1);
        wr(8'h00, 32'h0);

        // R8: zeros leave flags alone
        wr(8'h18, 32'h2);
        rd(8'h18, v); check("R8 other bit write", v, 1);
        wr(8'h18, 32'h0);
        rd(8'h18, v); check("R8 zero write", v, 1);
        wr(8'h18, 32'h1F);
        rd(8'h18, v); check("R8 clear all", v, 0);

        // R10 R7: resume frozen count 2 as one-shot, interrupt disabled
        wr(8'h00, 32'h4000_0000);
        wait_cyc(1);
        rd(8'h18, v); check("R7 resumed, not yet", v, 0);
        wait_cyc(1);
        rd(8'h18, v); check("R10 flag sets without enable", v, 1);
        check("R10 irq0 masked", {31'd0, irq0}, 0);
        rd(8'h00, v); check("R5 one-shot stopped", v, 0);
        wr(8'h00, 32'h2000_0000);
        check("R10 irq0 after enable", {31'd0, irq0}, 1);
        wr(8'h18, 32'h1);

        // R11 R3 R7: channel 1 running count, prescale 1
        wr(8'h0C, 32'd1000);
        wr(8'h04, 32'h4800_0001);
        rd(8'h14, v); check("R11 loaded", v, 1000);
        wait_cyc(1);
        rd(8'h14, v); check("R3 held one cycle", v, 1000);
        wait_cyc(1);
        rd(8'h14, v); check("R3 first step", v, 999);
        wait_cyc(5);
        rd(8'h14, v); check("R11 decreasing", v, 997);
        wr(8'h04, 32'h0800_0001);
        rd(8'h14, v); check("R7 halted", v, 996);
        wait_cyc(5);
        rd(8'h14, v); check("R7 frozen", v, 996);
        wr(8'h04, 32'h4800_0001);
        rd(8'h14, v); check("R7 no reload", v, 996);
        wait_cyc(2);
        rd(8'h14, v); check("R7 resumed step", v, 995);
        wr(8'h04, 32'h0800_0001);
        rd(8'h14, v); check("R7 halted again", v, 995);

        // R13: channel 0 expiry leaves channel 1 untouched
        wr(8'h18, 32'h3);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'd2);
        wr(8'h00, 32'h6000_0000);
        wait_cyc(2);
        rd(8'h18, v); check("R13 only flag 0", v, 1);
        rd(8'h14, v); check("R13 live1 unchanged", v, 995);
        check("R13 irq1 low", {31'd0, irq1}, 0);

        // R12: unmapped offsets
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        rd(8'h10, v); check("R12 read 0x10", v, 0);
        rd(8'h1C, v); check("R12 read 0x1C", v, 0);
        rd(8'h02, v); check("R12 read 0x02", v, 0);
        rd(8'h04, v); check("R12 ctrl1 intact", v, 32'h0800_0001);
        rd(8'h18, v); check("R12 flags intact", v, 1);
        rd(8'h14, v); check("R12 live1 intact", v, 995);

        // R1: reset mid-operation
        reset_and_check();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule